// File: doc/BRIEF.md
# End-of-Write Status Poller

This block sits on the host side of a byte-wide electrically erasable memory. It decides when the memory's internally timed page write or chip erase has finished. A single start pulse hands it three things: the address and true data of the last byte loaded, and a method select. It then issues a stream of single-byte reads to that address over a request/acknowledge read port. Each returned byte is judged by one of two rules. In data-polling mode, bit 7 is compared against the true bit 7. In toggle mode, bit 6 is compared against bit 6 of the read before it.

Completion is asynchronous to the reads, so one read that looks finished can be a coincidence. The poller therefore requires two further confirming reads before it raises done. The first confirming read is held back by a settle delay, so that the rest of the data bus has time to become valid. If a set number of reads passes without a confirmed completion, the poller raises a timeout flag instead. A chip erase can only be tracked by the toggling bit, so an erase request always selects toggle mode.

Top module: `eowp_poller`

## Requirements
- R1: After reset, and whenever reset is asserted mid-operation, `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are all 0.
- R2: `start_i` is accepted only while `busy_o` is 0. A start pulse during an operation changes neither the read address nor the number of reads, and it does not change the outcome.
- R3: In data-polling mode (`use_toggle_i`=0, `erase_i`=0), a returned byte looks complete when its bit 7 equals bit 7 of `data_i` as latched at start.
- R4: In toggle mode, a returned byte looks complete when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation never looks complete.
- R5: When `erase_i` is 1 at start, toggle mode is used whatever the value of `use_toggle_i`, and `data_i` plays no part.
- R6: Once a read looks complete, the next two reads must both look complete for `done_o` to rise, and it rises on the acknowledge of the second. If either confirming read fails, the poller returns to searching, and that failing read becomes the previous read for the toggle rule.
- R7: After the detecting read is acknowledged, the first confirming request waits `SETTLE_CYC` cycles in a settle state. With a memory that acknowledges one cycle after a request, the gap between the detecting acknowledge and the next acknowledge is `SETTLE_CYC`+2 cycles. The gap between ordinary back-to-back reads is 2 cycles.
- R8: If `MAX_POLLS` reads complete without done, `timeout_o` rises on the acknowledge of the last of them and `busy_o` falls. If that same read completes the confirmation, `done_o` rises instead.
- R9: `done_o` and `timeout_o` are never both 1. Each holds until the next accepted start, which clears it at the same edge at which `busy_o` rises.
- R10: Every read request carries the address latched at start. Only one read is outstanding at a time, and `rd_req_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| erase_i | input | 1 | Operation being tracked is a chip erase (forces toggle mode) |
| use_toggle_i | input | 1 | 1 selects toggle-bit polling, 0 selects data polling |
| addr_i | input | AW | Address of the last byte loaded |
| data_i | input | 8 | True data of the last byte loaded |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | One-cycle acknowledge carrying read data |
| rd_data_i | input | 8 | Read data, valid with `rd_ack_i` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion confirmed, held until next start |
| timeout_o | output | 1 | Poll limit reached, held until next start |

## Verification
The bench builds the poller with `MAX_POLLS`=12 and `SETTLE_CYC`=4, and keeps the default 17-bit address. A limit of twelve reads makes both boundaries reachable within a few dozen cycles. In one run, confirmation lands exactly on the twelfth read and done wins. In another, detection comes on the eleventh read, which leaves no room to confirm, and the result is a timeout. A four-cycle settle delay stands out clearly against the two-cycle rhythm of ordinary reads. The memory model can also plant a coincidental early match, which drives the path where a confirming read fails and searching resumes.

// File: rtl/eowp_pkg.sv
// Shared types for the end-of-write poller.
package eowp_pkg;

    // Controller states: idle, a read in flight, settle delay before confirming.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_SETTLE = 2'd2
    } eowp_state_e;

    // Rule used to judge a returned status byte.
    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } eowp_mode_e;

endpackage

// File: rtl/eowp_classify.sv
// Judges one returned status byte.
// Data mode: bit 7 must equal the true bit 7 of the last loaded byte.
// Toggle mode: bit 6 must equal bit 6 of the previous read; with no
// previous read in this operation the byte never looks complete.
// Assumes: purely combinational, inputs valid in the acknowledge cycle.
module eowp_classify
    import eowp_pkg::*;
(
    input  eowp_mode_e  mode,
    input  logic        true_b7,
    input  logic [7:0]  rd_data,
    input  logic        has_prev,
    input  logic        prev_b6,
    output logic        looks_done
);

    // Select the comparison for the active polling rule.
    always_comb begin
        if (mode == MODE_TOGGLE) begin
            looks_done = has_prev && (rd_data[6] == prev_b6);
        end else begin
            looks_done = (rd_data[7] == true_b7);
        end
    end

endmodule

// File: rtl/eowp_poll_count.sv
// Counts completed reads of one operation and flags the read that
// would be the last one allowed.
// Assumes: MAX_POLLS >= 1; clr and inc never assert together.
module eowp_poll_count #(
    parameter int MAX_POLLS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_read
);

    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    // Track how many reads have been acknowledged since start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_read = (cnt_q == LAST);

endmodule

// File: rtl/eowp_settle.sv
// Down-counter that spaces the detecting read from the first confirming
// read. After load, expire is high in the SETTLE_CYC-th following cycle.
// Assumes: SETTLE_CYC >= 1.
module eowp_settle #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);

    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SW-1:0] START = SW'(SETTLE_CYC - 1);

    logic [SW-1:0] rem_q;

    // Reload on detection, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= START;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign expire = (rem_q == '0);

endmodule

// File: rtl/eowp_poller.sv
// End-of-write status poller (top).
// Repeatedly reads the last loaded address after a page write or chip
// erase, detects completion by data polling or toggle bit, confirms it
// with two further reads (the first held back by a settle delay), and
// reports done or a timeout. Outputs hold until the next accepted start.
// Assumes: the memory answers each request with one rd_ack_i pulse and
// drops no request; SETTLE_CYC >= 1; MAX_POLLS >= 1.
module eowp_poller
    import eowp_pkg::*;
#(
    parameter int AW         = 17,
    parameter int MAX_POLLS  = 100000,
    parameter int SETTLE_CYC = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic          use_toggle_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o
);

    eowp_state_e   state_q;
    eowp_mode_e    mode_q;
    logic [AW-1:0] addr_q;
    logic          b7_q;
    logic [1:0]    conf_left_q;
    logic          has_prev_q;
    logic          prev_b6_q;
    logic          done_q;
    logic          tout_q;

    logic          looks_done;
    logic          last_read;
    logic          settle_expire;
    logic          accept;
    logic          got_read;
    logic          detect;
    logic          confirmed;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign got_read  = (state_q == ST_READ) && rd_ack_i;
    assign detect    = got_read && (conf_left_q == 2'd0) && looks_done;
    assign confirmed = got_read && (conf_left_q == 2'd1) && looks_done;

    eowp_classify u_classify (
        .mode       (mode_q),
        .true_b7    (b7_q),
        .rd_data    (rd_data_i),
        .has_prev   (has_prev_q),
        .prev_b6    (prev_b6_q),
        .looks_done (looks_done)
    );

    eowp_poll_count #(.MAX_POLLS(MAX_POLLS)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .inc       (got_read),
        .last_read (last_read)
    );

    eowp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (detect),
        .expire (settle_expire)
    );

    // Sequence the operation: latch on start, judge each read, settle, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_DATA;
            addr_q      <= '0;
            b7_q        <= 1'b0;
            conf_left_q <= 2'd0;
            has_prev_q  <= 1'b0;
            prev_b6_q   <= 1'b0;
            done_q      <= 1'b0;
            tout_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q      <= addr_i;
                        b7_q        <= data_i[7];
                        mode_q      <= (erase_i || use_toggle_i) ? MODE_TOGGLE : MODE_DATA;
                        conf_left_q <= 2'd0;
                        has_prev_q  <= 1'b0;
                        done_q      <= 1'b0;
                        tout_q      <= 1'b0;
                        state_q     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack_i) begin
                        has_prev_q <= 1'b1;
                        prev_b6_q  <= rd_data_i[6];
                        if (confirmed) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (last_read) begin
                            tout_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (detect) begin
                            conf_left_q <= 2'd2;
                            state_q     <= ST_SETTLE;
                        end else if (looks_done) begin
                            conf_left_q <= 2'd1;
                        end else begin
                            conf_left_q <= 2'd0;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_expire) begin
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_o  = (state_q == ST_READ);
    assign rd_addr_o = addr_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tout_q;

endmodule

// File: rtl/eowp_poller_chk.sv
// Protocol and outcome checks for eowp_poller, attached by bind.
// Keeps its own count of acknowledged reads per operation.
module eowp_poller_chk #(
    parameter int AW        = 17,
    parameter int MAX_POLLS = 100000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          timeout_o
);

    int unsigned reads_seen;

    // Count acknowledged reads since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_seen <= 0;
        end else if (start_i && !busy_o) begin
            reads_seen <= 0;
        end else if (rd_req_o && rd_ack_i) begin
            reads_seen <= reads_seen + 1;
        end
    end

    a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);

    a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r9_tout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !start_i) |=> timeout_o);

    a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rd_ack_i));

    a_r8_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
        reads_seen <= MAX_POLLS);

    a_r8_tout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (reads_seen == MAX_POLLS));

endmodule

bind eowp_poller eowp_poller_chk #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
);

// File: tb/eowp_poller_bench.sv
`timescale 1ns/1ps
// Self-checking bench for eowp_poller: vector table plus directed tests.
module eowp_poller_bench;

    localparam int AW  = 17;
    localparam int MAX = 12;
    localparam int SET = 4;

    // One scenario: mode, true data, busy reads, glitch read, outcome.
    typedef struct packed {
        logic       tog;
        logic       er;
        logic [7:0] d;
        logic [7:0] nbusy;
        logic [7:0] glitch;
        logic       exp_done;
        logic [7:0] exp_reads;
        logic [7:0] gap_idx;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'hA5, 8'd3,  8'd0, 1'b1, 8'd6,  8'd4 },  // R3 basic
        '{1'b0, 1'b0, 8'h3C, 8'd0,  8'd0, 1'b1, 8'd3,  8'd1 },  // R3 already done
        '{1'b0, 1'b0, 8'h80, 8'd5,  8'd2, 1'b1, 8'd8,  8'd0 },  // R6 confirm fails
        '{1'b0, 1'b0, 8'h11, 8'd9,  8'd0, 1'b1, 8'd12, 8'd10},  // R8 done on last
        '{1'b0, 1'b0, 8'h11, 8'd10, 8'd0, 1'b0, 8'd12, 8'd11},  // R8 timeout
        '{1'b1, 1'b0, 8'h40, 8'd3,  8'd0, 1'b1, 8'd6,  8'd4 },  // R4 early match
        '{1'b1, 1'b0, 8'h00, 8'd3,  8'd0, 1'b1, 8'd7,  8'd5 },  // R4 late match
        '{1'b1, 1'b0, 8'h40, 8'd0,  8'd0, 1'b1, 8'd4,  8'd2 },  // R4 first read
        '{1'b1, 1'b0, 8'h00, 8'd7,  8'd3, 1'b1, 8'd11, 8'd0 },  // R6 toggle glitch
        '{1'b0, 1'b1, 8'h00, 8'd4,  8'd0, 1'b1, 8'd8,  8'd6 },  // R5 erase
        '{1'b1, 1'b0, 8'h00, 8'd20, 8'd0, 1'b0, 8'd12, 8'd0 }   // R8 never stops
    };

    logic          clk;
    logic          rst_n;
    logic          start_i;
    logic          erase_i;
    logic          use_toggle_i;
    logic [AW-1:0] addr_i;
    logic [7:0]    data_i;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i;
    logic [7:0]    rd_data_i;
    logic          busy_o;
    logic          done_o;
    logic          timeout_o;

    int total;
    int bad;
    int cyc;

    // Memory model controls, written only by the stimulus process.
    logic          m_tog;
    logic [7:0]    m_d;
    int            m_busy;
    int            m_glitch;
    int            m_base;
    logic [AW-1:0] m_addr;

    // Memory model state, written only by the model process.
    int n_srv;
    int addr_err;
    int t_ack [32];

    eowp_poller #(.AW(AW), .MAX_POLLS(MAX), .SETTLE_CYC(SET)) u_eowp_poller (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .erase_i      (erase_i),
        .use_toggle_i (use_toggle_i),
        .addr_i       (addr_i),
        .data_i       (data_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .rd_ack_i     (rd_ack_i),
        .rd_data_i    (rd_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .timeout_o    (timeout_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Status byte the memory returns on read n (1-based) of an operation.
    function automatic logic [7:0] model_byte(input int n);
        logic b6;
        if (n > m_busy) return m_d;
        if (m_tog) begin
            b6 = (n == m_glitch) ? logic'((n - 1) % 2) : logic'(n % 2);
            return {1'b0, b6, 6'h00};
        end
        if (n == m_glitch) return m_d;
        return {~m_d[7], 7'h2A};
    endfunction

    // Memory: acknowledge one cycle after a request, log time and address.
    always @(posedge clk) begin
        int n;
        if (!rst_n) begin
            rd_ack_i <= 1'b0;
        end else if (rd_req_o && !rd_ack_i) begin
            n = n_srv - m_base + 1;
            rd_ack_i  <= 1'b1;
            rd_data_i <= model_byte(n);
            n_srv     <= n_srv + 1;
            if (n > 0 && n < 32) t_ack[n] <= cyc;
            if (rd_addr_o != m_addr) addr_err <= addr_err + 1;
        end else begin
            rd_ack_i <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm(input logic tog, input logic er, input logic [7:0] d,
                       input int nb, input int gl, input logic [AW-1:0] a);
        m_tog    = tog | er;
        m_d      = er ? 8'hFF : d;
        m_busy   = nb;
        m_glitch = gl;
        m_base   = n_srv;
        m_addr   = a;
    endtask

    task automatic pulse_start(input logic tog, input logic er, input logic [7:0] d,
                               input logic [AW-1:0] a);
        @(negedge clk);
        start_i = 1'b1; use_toggle_i = tog; erase_i = er; data_i = d; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    initial begin
        total = 0; bad = 0; cyc = 0; n_srv = 0; addr_err = 0;
        for (int i = 0; i < 32; i++) t_ack[i] = 0;
        start_i = 0; erase_i = 0; use_toggle_i = 0; addr_i = '0; data_i = '0;
        rd_data_i = '0;
        arm(1'b0, 1'b0, 8'h00, 0, 0, '0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(!busy_o && !rd_req_o && !done_o && !timeout_o, "R1 reset state",
              {busy_o, rd_req_o, done_o, timeout_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            int ae;
            int gi;
            a  = AW'(17'h00100 + v * 37);
            ae = addr_err;
            arm(VEC[v].tog, VEC[v].er, VEC[v].d, int'(VEC[v].nbusy), int'(VEC[v].glitch), a);
            pulse_start(VEC[v].tog, VEC[v].er, VEC[v].d, a);
            check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
            wait_idle();
            check(done_o == VEC[v].exp_done, "R6/R8 done outcome", done_o, VEC[v].exp_done);
            check(timeout_o == !VEC[v].exp_done, "R8 timeout outcome", timeout_o, !VEC[v].exp_done);
            check(n_srv - m_base == int'(VEC[v].exp_reads), "R3/R4/R5 read count",
                  n_srv - m_base, VEC[v].exp_reads);
            check(addr_err == ae, "R10 read address", addr_err - ae, 0);
            gi = int'(VEC[v].gap_idx);
            if (gi != 0) begin
                check(t_ack[gi+1] - t_ack[gi] == SET + 2, "R7 settle gap",
                      t_ack[gi+1] - t_ack[gi], SET + 2);
                if (gi > 1)
                    check(t_ack[gi] - t_ack[gi-1] == 2, "R7 plain gap",
                          t_ack[gi] - t_ack[gi-1], 2);
            end
            repeat (2) @(negedge clk);
        end

        // R2: start while busy is ignored
        begin
            int ae;
            ae = addr_err;
            arm(1'b0, 1'b0, 8'hA5, 3, 0, 17'h01234);
            pulse_start(1'b0, 1'b0, 8'hA5, 17'h01234);
            repeat (2) @(negedge clk);
            start_i = 1'b1; use_toggle_i = 1'b1; addr_i = 17'h00F0F; data_i = 8'h00;
            @(negedge clk);
            start_i = 1'b0;
            wait_idle();
            check(done_o == 1'b1, "R2 outcome unchanged", done_o, 1);
            check(n_srv - m_base == 6, "R2 read count unchanged", n_srv - m_base, 6);
            check(addr_err == ae, "R2 address unchanged", addr_err - ae, 0);
        end

        // R9: done holds while idle
        repeat (20) @(negedge clk);
        check(done_o == 1'b1 && !busy_o, "R9 done held", done_o, 1);

        // R9: timeout holds, then next start clears it
        arm(1'b1, 1'b0, 8'h00, 20, 0, 17'h00042);
        pulse_start(1'b1, 1'b0, 8'h00, 17'h00042);
        wait_idle();
        check(timeout_o == 1'b1 && !done_o, "R9 timeout set", timeout_o, 1);
        repeat (15) @(negedge clk);
        check(timeout_o == 1'b1, "R9 timeout held", timeout_o, 1);
        arm(1'b0, 1'b0, 8'h3C, 0, 0, 17'h00043);
        @(negedge clk);
        start_i = 1'b1; use_toggle_i = 1'b0; erase_i = 1'b0; data_i = 8'h3C; addr_i = 17'h00043;
        @(negedge clk);
        start_i = 1'b0;
        check(!timeout_o && !done_o && busy_o, "R9 start clears flags",
              {timeout_o, done_o, busy_o}, 1);
        wait_idle();
        check(done_o == 1'b1, "R9 follow-up done", done_o, 1);

        // R1: reset in the middle of an operation
        arm(1'b1, 1'b0, 8'h00, 20, 0, 17'h00077);
        pulse_start(1'b1, 1'b0, 8'h00, 17'h00077);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !rd_req_o && !done_o && !timeout_o, "R1 mid-op reset",
              {busy_o, rd_req_o, done_o, timeout_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !rd_req_o, "R1 stays idle", {busy_o, rd_req_o}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule